// File: doc/BRIEF.md
# Frequent Loop Profiler

The profiler sits beside a processor and watches its instruction fetch stream without ever driving anything back towards the processor. A fetch is a loop event when it is valid, the branch it carries is taken, and the branch destination lies at a lower address than the fetch address. Every distinct branch address that produces such an event gets a slot in a twelve-entry fully associative table. The slot's counter goes up each time that branch fires again.

When a new branch arrives and every slot is in use, the slot with the smallest count is given to the newcomer. Counters are 16 bits wide and never wrap. When a branch hits a slot that is already at the top value, every counter in the table is halved in that same cycle, so the ranking between branches is kept. The hottest slot is reported all the time on a dedicated output group. A separate read port lets host software walk the table slot by slot. A synchronous clear empties the table.

Top module: `loop_profiler`

## Requirements
- R1: After reset, and in the cycle after `clear` is sampled high, every slot is empty: `hotValid` is 0 and every slot reads back with `rdValid`=0, `rdAddr`=0 and `rdCount`=0. `clear` takes priority over a loop event in the same cycle.
- R2: A loop event needs all three of these: `fetchValid`=1, `branchTaken`=1 and `branchTarget` strictly below `fetchAddr` (unsigned). A forward branch, an equal destination, a not-taken branch or an idle fetch leaves the table and the hot outputs unchanged.
- R3: A loop event whose `fetchAddr` matches no occupied slot, while a slot is free, fills the lowest-numbered free slot with key `fetchAddr` and count 1. The change is visible at the outputs right after the clock edge that samples the event.
- R4: A loop event whose `fetchAddr` matches an occupied slot raises that slot's count by exactly 1, as long as the count is below 0xFFFF.
- R5: A loop event that misses while all 12 slots are occupied overwrites the slot with the lowest count with key `fetchAddr` and count 1. On equal counts the lowest slot number wins.
- R6: A loop event that hits a slot already holding 0xFFFF sets that slot to 0x8000 and shifts every other slot's count right by one bit, all in a single cycle. No counter ever wraps to 0.
- R7: `hotValid` is 1 whenever any slot is occupied. `hotIndex`, `hotAddr` and `hotCount` then describe the occupied slot with the highest count, and on equal counts the lowest slot number.
- R8: `rdIndex` values 0 to 11 select a slot for `rdValid`/`rdAddr`/`rdCount`. Values 12 to 15 return 0 on all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous table clear |
| fetchValid | input | 1 | Fetch address on the bus is valid |
| fetchAddr | input | 32 | Address of the fetched instruction |
| branchTaken | input | 1 | The fetched instruction transfers control |
| branchTarget | input | 32 | Destination of the transfer |
| rdIndex | input | 4 | Host read slot select |
| rdValid | output | 1 | Selected slot is occupied |
| rdAddr | output | 32 | Branch address held in the selected slot |
| rdCount | output | 16 | Count held in the selected slot |
| hotValid | output | 1 | At least one slot is occupied |
| hotIndex | output | 4 | Slot number of the hottest entry |
| hotAddr | output | 32 | Branch address of the hottest entry |
| hotCount | output | 16 | Count of the hottest entry |

## Verification
The bench aims at the edges of the loop-event test: an equal destination, a forward branch, a not-taken branch and an idle fetch. A comparison off by one bit, or one that ignores a qualifier, would count these as loops, and the table would change. Replacement is driven with several slots tied at the lowest count. A victim search that is not biased to the lowest slot would overwrite the wrong entry, and so would one that compares with the wrong sense. One branch is pushed to exactly 0xFFFF and hit once more. A design that wraps, saturates without halving, or halves only the hit slot would show the wrong value for the hottest entry or for the companion entry. Long random runs over a pool larger than the table exercise hit, fill and eviction together, and check every slot after every cycle.

// File: rtl/loop_prof_pkg.sv
package loop_prof_pkg;
  localparam int ENTRIES = 12;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 16;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam cnt_t CNT_MAX     = '1;
  localparam cnt_t CNT_HALF_UP = cnt_t'({1'b1, {(CNT_W-1){1'b0}}});

  // strobes from the control side to the table
  typedef struct packed {
    logic  clearAll;
    logic  bumpEn;
    logic  halveAll;
    logic  fillEn;
    idx_t  slot;
    addr_t key;
  } strobe_t;
endpackage

// File: rtl/loop_prof_ctrl.sv
module loop_prof_ctrl
  import loop_prof_pkg::*;
(
  input  logic                clear,
  input  logic                fetchValid,
  input  addr_t               fetchAddr,
  input  logic                branchTaken,
  input  addr_t               branchTarget,
  input  logic [ENTRIES-1:0]  valids,
  input  addr_t [ENTRIES-1:0] keys,
  input  cnt_t  [ENTRIES-1:0] cnts,
  output strobe_t             stb,
  output logic                hotValid,
  output idx_t                hotIndex,
  output addr_t               hotAddr,
  output cnt_t                hotCount
);
  logic isBackward;
  logic hit, freeFound, hotFound;
  idx_t hitIdx, freeIdx, victimIdx, hotIdx;
  cnt_t victimCnt, hotCnt;

  assign isBackward = fetchValid & branchTaken & (branchTarget < fetchAddr);

  // associative match and free-slot search, lowest index first
  always_comb begin
    hit = 1'b0;
    hitIdx = '0;
    freeFound = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && valids[i] && keys[i] == fetchAddr) begin
        hit = 1'b1;
        hitIdx = idx_t'(i);
      end
      if (!freeFound && !valids[i]) begin
        freeFound = 1'b1;
        freeIdx = idx_t'(i);
      end
    end
  end

  // victim: minimum count, strict compare keeps the lowest index on ties
  always_comb begin
    victimIdx = '0;
    victimCnt = cnts[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (cnts[i] < victimCnt) begin
        victimCnt = cnts[i];
        victimIdx = idx_t'(i);
      end
    end
  end

  // hottest occupied entry, lowest index on ties
  always_comb begin
    hotFound = 1'b0;
    hotIdx = '0;
    hotCnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valids[i] && (!hotFound || cnts[i] > hotCnt)) begin
        hotFound = 1'b1;
        hotIdx = idx_t'(i);
        hotCnt = cnts[i];
      end
    end
  end

  assign hotValid = hotFound;
  assign hotIndex = hotIdx;
  assign hotCount = hotCnt;
  assign hotAddr  = hotFound ? keys[hotIdx] : '0;

  always_comb begin
    stb = '0;
    stb.clearAll = clear;
    if (!clear && isBackward) begin
      stb.key = fetchAddr;
      if (hit) begin
        stb.bumpEn   = 1'b1;
        stb.slot     = hitIdx;
        stb.halveAll = (cnts[hitIdx] == CNT_MAX);
      end else begin
        stb.fillEn = 1'b1;
        stb.slot   = freeFound ? freeIdx : victimIdx;
      end
    end
  end
endmodule

// File: rtl/loop_prof_dp.sv
module loop_prof_dp
  import loop_prof_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  idx_t                rdIndex,
  output logic [ENTRIES-1:0]  valids,
  output addr_t [ENTRIES-1:0] keys,
  output cnt_t  [ENTRIES-1:0] cnts,
  output logic                rdValid,
  output addr_t               rdAddr,
  output cnt_t                rdCount
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic mine;
    assign mine = (stb.slot == idx_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valids[g] <= 1'b0;
        keys[g]   <= '0;
        cnts[g]   <= '0;
      end else if (stb.clearAll) begin
        valids[g] <= 1'b0;
        keys[g]   <= '0;
        cnts[g]   <= '0;
      end else if (stb.halveAll) begin
        cnts[g] <= (stb.bumpEn && mine) ? CNT_HALF_UP : (cnts[g] >> 1);
      end else if (stb.bumpEn && mine) begin
        cnts[g] <= cnts[g] + cnt_t'(1);
      end else if (stb.fillEn && mine) begin
        valids[g] <= 1'b1;
        keys[g]   <= stb.key;
        cnts[g]   <= cnt_t'(1);
      end
    end
  end

  always_comb begin
    rdValid = 1'b0;
    rdAddr  = '0;
    rdCount = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rdIndex == idx_t'(i)) begin
        rdValid = valids[i];
        rdAddr  = keys[i];
        rdCount = cnts[i];
      end
    end
  end
endmodule

// File: rtl/loop_profiler.sv
module loop_profiler
  import loop_prof_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        fetchValid,
  input  logic [31:0] fetchAddr,
  input  logic        branchTaken,
  input  logic [31:0] branchTarget,
  input  logic [3:0]  rdIndex,
  output logic        rdValid,
  output logic [31:0] rdAddr,
  output logic [15:0] rdCount,
  output logic        hotValid,
  output logic [3:0]  hotIndex,
  output logic [31:0] hotAddr,
  output logic [15:0] hotCount
);
  strobe_t             stb;
  logic [ENTRIES-1:0]  valids;
  addr_t [ENTRIES-1:0] keys;
  cnt_t  [ENTRIES-1:0] cnts;

  loop_prof_ctrl u_ctrl (
    .clear(clear), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .valids(valids), .keys(keys), .cnts(cnts), .stb(stb),
    .hotValid(hotValid), .hotIndex(hotIndex), .hotAddr(hotAddr),
    .hotCount(hotCount)
  );

  loop_prof_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rdIndex(rdIndex),
    .valids(valids), .keys(keys), .cnts(cnts),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdCount(rdCount)
  );
endmodule

// File: rtl/loop_prof_checker.sv
module loop_prof_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        fetchValid,
  input logic [31:0] fetchAddr,
  input logic        branchTaken,
  input logic [31:0] branchTarget,
  input logic [3:0]  rdIndex,
  input logic        rdValid,
  input logic [31:0] rdAddr,
  input logic [15:0] rdCount,
  input logic        hotValid,
  input logic [3:0]  hotIndex,
  input logic [31:0] hotAddr,
  input logic [15:0] hotCount
);
  logic loopEvt;
  assign loopEvt = fetchValid && branchTaken && (branchTarget < fetchAddr);

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hotValid);

  assert_quiet_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !loopEvt) |=> ($stable(hotValid) && $stable(hotCount)
                              && $stable(hotAddr) && $stable(hotIndex)));

  assert_event_occupies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && loopEvt) |=> hotValid);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && loopEvt && hotValid) |=>
      ((hotCount >= $past(hotCount)) || (hotCount == 16'h8000)));

  assert_hot_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hotValid |-> (hotCount != 16'h0000));

  assert_rd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIndex >= 4'd12) |-> (!rdValid && rdCount == 16'h0 && rdAddr == 32'h0));
endmodule

bind loop_profiler loop_prof_checker u_chk (.*);

// File: tb/loop_profiler_bench.sv
module loop_profiler_bench;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        branchTaken = 1'b0;
  logic [31:0] branchTarget = '0;
  logic [3:0]  rdIndex = '0;
  logic        rdValid, hotValid;
  logic [31:0] rdAddr, hotAddr;
  logic [15:0] rdCount, hotCount;
  logic [3:0]  hotIndex;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit          mV [N];
  logic [31:0] mK [N];
  logic [15:0] mC [N];

  always #10 clk = ~clk;

  loop_profiler u_loop_profiler (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin mV[i] = 0; mK[i] = '0; mC[i] = '0; end
  endtask

  task automatic modelStep(bit fv, logic [31:0] fa, bit bt, logic [31:0] tg, bit clr);
    int h, f, v;
    if (clr) begin modelClear(); return; end
    if (!(fv && bt && tg < fa)) return;
    h = -1; f = -1; v = 0;
    for (int i = 0; i < N; i++) begin
      if (h < 0 && mV[i] && mK[i] == fa) h = i;
      if (f < 0 && !mV[i]) f = i;
      if (mC[i] < mC[v]) v = i;
    end
    if (h >= 0) begin
      if (mC[h] == 16'hFFFF) begin
        for (int i = 0; i < N; i++) mC[i] = mC[i] >> 1;
        mC[h] = 16'h8000;
      end else mC[h] = mC[h] + 16'd1;
    end else begin
      if (f < 0) f = v;
      mV[f] = 1; mK[f] = fa; mC[f] = 16'd1;
    end
  endtask

  task automatic compareAll();
    int hi;
    hi = -1;
    for (int i = 0; i < N; i++)
      if (mV[i] && (hi < 0 || mC[i] > mC[hi])) hi = i;
    chk("R7 hotValid", {31'b0, hotValid}, {31'b0, hi >= 0});
    if (hi >= 0) begin
      chk("R7 hotIndex", {28'b0, hotIndex}, hi);
      chk("R7 hotAddr", hotAddr, mK[hi]);
      chk("R7 hotCount", {16'b0, hotCount}, {16'b0, mC[hi]});
    end
    for (int i = 0; i < N; i++) begin
      rdIndex = 4'(i);
      #1;
      chk("R4 rdValid", {31'b0, rdValid}, {31'b0, mV[i]});
      chk("R3 rdAddr", rdAddr, mK[i]);
      chk("R5 rdCount", {16'b0, rdCount}, {16'b0, mC[i]});
    end
  endtask

  task automatic cyc(bit fv, logic [31:0] fa, bit bt, logic [31:0] tg, bit clr, bit full);
    fetchValid = fv; fetchAddr = fa; branchTaken = bt; branchTarget = tg; clear = clr;
    @(posedge clk);
    modelStep(fv, fa, bt, tg, clr);
    @(negedge clk);
    fetchValid = 0; branchTaken = 0; clear = 0;
    if (full) compareAll();
  endtask

  task automatic loopHit(logic [31:0] a, bit full);
    cyc(1, a, 1, a - 32'h20, 0, full);
  endtask

  initial begin
    void'($urandom(32'd7));
    modelClear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hotValid after reset", {31'b0, hotValid}, 32'd0);
    compareAll();

    // R2 non-events
    cyc(1, 32'h100, 1, 32'h200, 0, 1);
    cyc(1, 32'h100, 1, 32'h100, 0, 1);
    cyc(1, 32'h200, 0, 32'h100, 0, 1);
    cyc(0, 32'h200, 1, 32'h100, 0, 1);
    chk("R2 nothing counted", {31'b0, hotValid}, 32'd0);

    // R3 first fill, R4 bump
    cyc(1, 32'h200, 1, 32'h100, 0, 1);
    chk("R3 count one", {16'b0, hotCount}, 32'd1);
    loopHit(32'h200, 1);
    chk("R4 count two", {16'b0, hotCount}, 32'd2);

    // R7 tie then overtake
    loopHit(32'h300, 1);
    loopHit(32'h300, 1);
    chk("R7 tie lowest index", {28'b0, hotIndex}, 32'd0);
    loopHit(32'h300, 1);
    chk("R7 overtake", {28'b0, hotIndex}, 32'd1);

    // R1 clear wins over a simultaneous event
    cyc(1, 32'h500, 1, 32'h100, 1, 1);
    chk("R1 cleared", {31'b0, hotValid}, 32'd0);

    // R5 fill table, leave slots 3 and 7 at count 1
    for (int i = 0; i < N; i++) loopHit(32'h1000 + 32'(i) * 32'h10, 0);
    for (int i = 0; i < N; i++) if (i != 3 && i != 7) loopHit(32'h1000 + 32'(i) * 32'h10, 0);
    loopHit(32'h8000, 1);
    rdIndex = 4'd3; #1;
    chk("R5 victim key", rdAddr, 32'h8000);
    chk("R5 victim count", {16'b0, rdCount}, 32'd1);
    loopHit(32'h9000, 1);
    rdIndex = 4'd3; #1;
    chk("R5 tie lowest slot", rdAddr, 32'h9000);

    // R8 out-of-range reads
    rdIndex = 4'd12; #1;
    chk("R8 idx12 valid", {31'b0, rdValid}, 32'd0);
    chk("R8 idx12 count", {16'b0, rdCount}, 32'd0);
    rdIndex = 4'd15; #1;
    chk("R8 idx15 addr", rdAddr, 32'd0);

    // R6 saturation and halving
    cyc(0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 65535; i++) loopHit(32'h4000, 0);
    for (int i = 0; i < 3; i++) loopHit(32'h4400, 0);
    compareAll();
    chk("R6 at max", {16'b0, hotCount}, 32'h0000FFFF);
    loopHit(32'h4000, 1);
    chk("R6 halved hot", {16'b0, hotCount}, 32'h00008000);
    rdIndex = 4'd1; #1;
    chk("R6 other halved", {16'b0, rdCount}, 32'd1);

    // random mix over a pool larger than the table
    cyc(0, 0, 0, 0, 1, 1);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fa, tg;
      int r;
      fa = 32'h1000 + (32'($urandom % 20) << 4);
      r = $urandom % 4;
      tg = (r == 0) ? fa + 32'h8 : (r == 1) ? fa : fa - 32'h40;
      cyc(($urandom % 8) != 0, fa, ($urandom % 4) != 0, tg, ($urandom % 500) == 0, 1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule